// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a bank of SDRAM rows out of power-up and hands it to normal operation. After a start pulse it counts out a settling period, then steps through the JEDEC-style bring-up: NOP, precharge-all, eight CBR refreshes and a mode-register load. It then returns the controller to normal mode and turns refresh on. Every wait is a parameter counted in clock cycles.

Each non-normal command is delivered as a one-cycle strobe to every populated row in turn. The strobe carries the 3-bit command mode, the target row index and an access address. The access address is the row's base address. For the mode-register load, the mode word shifted left by three bits is added to that base. A done flag stays high from completion until the next start.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, cmd_mode_o is 0 (normal), cmd_vld_o, refresh_en_o and done_o are low.
- R2: When start_i is sampled high in cycle c0 while idle or finished, cmd_mode_o stays 0 through cycle c0+T_PWR_CYC. In cycle c0+T_PWR_CYC+1 it becomes 1 (NOP).
- R3: cmd_mode_o only takes the codes 0 normal, 1 NOP, 2 precharge-all, 3 mode-register-set and 4 CBR refresh. Codes 5 to 7 never appear, and no strobe is issued in normal mode.
- R4: Each command phase strobes cmd_vld_o once for every row whose row_valid_i bit is set. Rows are visited in ascending index order, on consecutive cycles starting the cycle after the mode changes. Empty rows are skipped, and a phase with no populated rows issues no strobe.
- R5: For codes 1, 2 and 4, cmd_addr_o equals the base address of the strobed row. For code 3 it equals that base plus 0x1D0 when cas3_i is 1 (CAS latency 3) or 0x150 when cas3_i is 0 (CAS latency 2). These offsets are the mode word shifted left by 3. The mode word is burst length code 010 in bits 2:0, interleaved burst type 1 in bit 3, CAS code 011 or 010 in bits 6:4, and zero above.
- R6: The phases run in the order NOP, precharge-all, exactly eight CBR phases, mode-register-set, then normal mode.
- R7: Let L be the cycle of a phase's last strobe, or the cycle its mode was set if it had none. The next mode change happens in cycle L+W+1. W is T_NOP_CYC after NOP, T_RP_CYC after precharge, T_RC_CYC after each CBR and T_MRD_CYC after mode-register-set.
- R8: refresh_en_o is low from the cycle after an accepted start until one cycle after cmd_mode_o returns to 0 at the end of the sequence. In that cycle it goes high.
- R9: done_o rises together with refresh_en_o. Both hold, with no further strobes, until the next accepted start, and both are low in the cycle after it.
- R10: A start pulse while a sequence is running, including the final cycle before refresh is enabled, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the sequence (accepted when idle or finished) |
| row_valid_i | input | ROWS | Row populated flags |
| row_base_i | input | ROWS x AW | Per-row base address |
| cas3_i | input | 1 | 1 selects CAS latency 3, 0 selects CAS latency 2 |
| cmd_mode_o | output | 3 | Current command mode |
| cmd_vld_o | output | 1 | Command access strobe |
| cmd_addr_o | output | AW | Access address for the strobe |
| cmd_row_o | output | RW | Row index for the strobe |
| refresh_en_o | output | 1 | Refresh enable |
| done_o | output | 1 | Sequence complete |

## Verification
Completion and a new start can meet in the same cycle. The bench drives start_i in the cycle where the mode has just returned to normal but refresh is not yet on. That start must be ignored, with refresh and done rising one cycle later as scheduled. It then keeps start_i high into the first cycle with done set. That start must restart the sequence, clear both flags and reproduce the full strobe schedule from that cycle. Every strobe's cycle, mode, row and address is compared against a schedule computed from the row mask, base addresses and wait parameters. Random row masks, including the empty and single-row cases, are mixed in.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  typedef enum logic [2:0] {
    CMD_NORMAL = 3'd0,
    CMD_NOP    = 3'd1,
    CMD_PREALL = 3'd2,
    CMD_MRS    = 3'd3,
    CMD_CBR    = 3'd4
  } sdi_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_BCAST,
    ST_GAP,
    ST_REF,
    ST_FIN
  } sdi_state_e;
endpackage

// File: rtl/sdi_row_pick.sv
module sdi_row_pick #(
  parameter int ROWS = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0] pend_i,
  output logic            any_o,
  output logic [RW-1:0]   idx_o
);
  // lowest pending row wins
  always_comb begin
    idx_o = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = RW'(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/sdi_wait_timer.sv
module sdi_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdi_mrs_addr.sv
module sdi_mrs_addr #(
  parameter int         AW       = 32,
  parameter logic [2:0] BL_CODE  = 3'b010,
  parameter logic       BURST_IL = 1'b1
) (
  input  logic          cas3_i,
  output logic [AW-1:0] off_o
);
  logic [2:0]  cas_code;
  logic [11:0] mode_word;

  assign cas_code  = cas3_i ? 3'b011 : 3'b010;
  // op mode 8:7 and write-burst/reserved bits kept at zero
  assign mode_word = {5'b00000, cas_code, BURST_IL, BL_CODE};
  assign off_o     = AW'(mode_word) << 3;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdi_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int AW        = 32,
  parameter int T_PWR_CYC = 20000,
  parameter int T_NOP_CYC = 200,
  parameter int T_RP_CYC  = 3,
  parameter int T_RC_CYC  = 7,
  parameter int T_MRD_CYC = 2,
  parameter int CBR_N     = 8,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (CBR_N > 1) ? $clog2(CBR_N) : 1,
  localparam int MAXA = (T_PWR_CYC > T_NOP_CYC) ? T_PWR_CYC : T_NOP_CYC,
  localparam int MAXB = (T_RP_CYC > T_RC_CYC) ? T_RP_CYC : T_RC_CYC,
  localparam int MAXC = (MAXA > MAXB) ? MAXA : MAXB,
  localparam int MAXW = (MAXC > T_MRD_CYC) ? MAXC : T_MRD_CYC,
  localparam int TW   = $clog2(MAXW + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ROWS-1:0]        row_valid_i,
  input  logic [ROWS-1:0][AW-1:0] row_base_i,
  input  logic                   cas3_i,
  output logic [2:0]             cmd_mode_o,
  output logic                   cmd_vld_o,
  output logic [AW-1:0]          cmd_addr_o,
  output logic [RW-1:0]          cmd_row_o,
  output logic                   refresh_en_o,
  output logic                   done_o
);
  sdi_state_e      st_q;
  sdi_cmd_e        cmd_q;
  logic [CW-1:0]   cbr_q;
  logic [ROWS-1:0] pend_q;
  logic            vld_q, ref_q, done_q;
  logic [RW-1:0]   row_q;
  logic [AW-1:0]   addr_q;

  logic            pick_any;
  logic [RW-1:0]   pick_idx;
  logic [AW-1:0]   mrs_off;
  logic            tmr_load, tmr_zero;
  logic [TW-1:0]   tmr_val;
  logic            start_ok;

  sdi_row_pick #(.ROWS(ROWS)) u_pick (
    .pend_i (pend_q),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  sdi_mrs_addr #(.AW(AW)) u_mrs (
    .cas3_i (cas3_i),
    .off_o  (mrs_off)
  );

  sdi_wait_timer #(.TW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  function automatic logic [TW-1:0] gap_len(sdi_cmd_e c);
    case (c)
      CMD_NOP:    return TW'(T_NOP_CYC - 1);
      CMD_PREALL: return TW'(T_RP_CYC - 1);
      CMD_CBR:    return TW'(T_RC_CYC - 1);
      default:    return TW'(T_MRD_CYC - 1);
    endcase
  endfunction

  assign start_ok = start_i && ((st_q == ST_IDLE) || (st_q == ST_FIN));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_ok) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(T_PWR_CYC - 1);
    end else if ((st_q == ST_BCAST) && !pick_any) begin
      tmr_load = 1'b1;
      tmr_val  = gap_len(cmd_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NORMAL;
      cbr_q  <= '0;
      pend_q <= '0;
      vld_q  <= 1'b0;
      row_q  <= '0;
      addr_q <= '0;
      ref_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (st_q)
        ST_IDLE, ST_FIN: begin
          if (start_i) begin
            st_q   <= ST_PWR;
            ref_q  <= 1'b0;
            done_q <= 1'b0;
          end
        end
        ST_PWR: begin
          if (tmr_zero) begin
            st_q   <= ST_BCAST;
            cmd_q  <= CMD_NOP;
            pend_q <= row_valid_i;
          end
        end
        ST_BCAST: begin
          if (pick_any) begin
            vld_q            <= 1'b1;
            row_q            <= pick_idx;
            addr_q           <= row_base_i[pick_idx] + ((cmd_q == CMD_MRS) ? mrs_off : '0);
            pend_q[pick_idx] <= 1'b0;
          end else begin
            st_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tmr_zero) begin
            st_q   <= ST_BCAST;
            pend_q <= row_valid_i;
            case (cmd_q)
              CMD_NOP:    cmd_q <= CMD_PREALL;
              CMD_PREALL: begin
                cmd_q <= CMD_CBR;
                cbr_q <= '0;
              end
              CMD_CBR: begin
                if (cbr_q == CW'(CBR_N - 1)) cmd_q <= CMD_MRS;
                else                         cbr_q <= cbr_q + 1'b1;
              end
              default: begin
                cmd_q <= CMD_NORMAL;
                st_q  <= ST_REF;
              end
            endcase
          end
        end
        ST_REF: begin
          ref_q  <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_mode_o   = cmd_q;
  assign cmd_vld_o    = vld_q;
  assign cmd_addr_o   = addr_q;
  assign cmd_row_o    = row_q;
  assign refresh_en_o = ref_q;
  assign done_o       = done_q;
endmodule

// File: rtl/sdi_checker.sv
module sdi_checker #(
  parameter int ROWS = 8,
  parameter int AW   = 32,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ROWS-1:0]         row_valid_i,
  input logic [ROWS-1:0][AW-1:0] row_base_i,
  input logic [2:0]              cmd_mode_o,
  input logic                    cmd_vld_o,
  input logic [AW-1:0]           cmd_addr_o,
  input logic [RW-1:0]           cmd_row_o,
  input logic                    refresh_en_o,
  input logic                    done_o
);
  assert_mode_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_mode_o <= 3'd4);

  assert_no_normal_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> cmd_mode_o != 3'd0);

  assert_row_populated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> row_valid_i[cmd_row_o]);

  assert_rows_ascend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && $past(cmd_vld_o)) |-> cmd_row_o > $past(cmd_row_o));

  assert_plain_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && cmd_mode_o != 3'd3) |-> cmd_addr_o == row_base_i[cmd_row_o]);

  assert_ref_in_normal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refresh_en_o) |-> (cmd_mode_o == 3'd0 && $past(cmd_mode_o) == 3'd0));

  assert_quiet_when_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_en_o |-> !cmd_vld_o);

  assert_done_with_ref_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> refresh_en_o);
endmodule

bind sdram_init_seq sdi_checker #(.ROWS(ROWS), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .row_valid_i  (row_valid_i),
  .row_base_i   (row_base_i),
  .cmd_mode_o   (cmd_mode_o),
  .cmd_vld_o    (cmd_vld_o),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_row_o    (cmd_row_o),
  .refresh_en_o (refresh_en_o),
  .done_o       (done_o)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  localparam int ROWS  = 8;
  localparam int AW    = 32;
  localparam int W_PWR = 30;
  localparam int W_NOP = 10;
  localparam int W_RP  = 2;
  localparam int W_RC  = 3;
  localparam int W_MRD = 2;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    start_i = 1'b0;
  logic [ROWS-1:0]         row_valid_i = '0;
  logic [ROWS-1:0][AW-1:0] row_base_i = '0;
  logic                    cas3_i = 1'b1;
  logic [2:0]              cmd_mode_o;
  logic                    cmd_vld_o;
  logic [AW-1:0]           cmd_addr_o;
  logic [2:0]              cmd_row_o;
  logic                    refresh_en_o;
  logic                    done_o;

  sdram_init_seq #(
    .ROWS(ROWS), .AW(AW), .T_PWR_CYC(W_PWR), .T_NOP_CYC(W_NOP),
    .T_RP_CYC(W_RP), .T_RC_CYC(W_RC), .T_MRD_CYC(W_MRD)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .row_valid_i(row_valid_i), .row_base_i(row_base_i), .cas3_i(cas3_i),
    .cmd_mode_o(cmd_mode_o), .cmd_vld_o(cmd_vld_o), .cmd_addr_o(cmd_addr_o),
    .cmd_row_o(cmd_row_o), .refresh_en_o(refresh_en_o), .done_o(done_o)
  );

  always #10 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // expected schedule
  int          e_cyc [128];
  int          e_mode[128];
  int          e_row [128];
  logic [31:0] e_addr[128];
  int          n_exp = 0;
  int          ptr = 0;
  int          ph_cyc [16];
  int          ph_mode[16];
  int          n_ph = 0;
  int          t_norm = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_mode_at(int c);
    int m = 0;
    for (int i = 0; i < n_ph; i++) if (ph_cyc[i] <= c) m = ph_mode[i];
    return m;
  endfunction

  task automatic build(input int c0, input logic [7:0] mask, input bit cas3);
    int k = c0 + W_PWR + 1;
    n_exp = 0;
    n_ph  = 0;
    ptr   = 0;
    for (int p = 0; p < 11; p++) begin
      int md = (p == 0) ? 1 : (p == 1) ? 2 : (p <= 9) ? 4 : 3;
      int w  = (p == 0) ? W_NOP : (p == 1) ? W_RP : (p <= 9) ? W_RC : W_MRD;
      int l  = k;
      ph_cyc[n_ph] = k; ph_mode[n_ph] = md; n_ph++;
      for (int r = 0; r < ROWS; r++) begin
        if (mask[r]) begin
          l++;
          e_cyc[n_exp]  = l;
          e_mode[n_exp] = md;
          e_row[n_exp]  = r;
          e_addr[n_exp] = row_base_i[r] + ((md == 3) ? (cas3 ? 32'h1D0 : 32'h150) : 32'h0);
          n_exp++;
        end
      end
      k = l + w + 1;
    end
    ph_cyc[n_ph] = k; ph_mode[n_ph] = 0; n_ph++;
    t_norm = k;
  endtask

  // monitor: strobe schedule (R4 R5 R6 R7) and mode timeline (R2 R3 R6)
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk(cmd_mode_o == 3'(exp_mode_at(cyc)), "R6 mode timeline", cmd_mode_o, exp_mode_at(cyc));
      if (cmd_vld_o) begin
        if (ptr >= n_exp) begin
          chk(1'b0, "R4 unexpected strobe", cmd_row_o, 0);
        end else begin
          chk(cyc == e_cyc[ptr], "R7 strobe cycle", cyc, e_cyc[ptr]);
          chk(int'(cmd_mode_o) == e_mode[ptr], "R6 strobe mode", cmd_mode_o, e_mode[ptr]);
          chk(int'(cmd_row_o) == e_row[ptr], "R4 strobe row", cmd_row_o, e_row[ptr]);
          chk(cmd_addr_o == e_addr[ptr], "R5 strobe addr", cmd_addr_o, e_addr[ptr]);
          ptr++;
        end
      end
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  // caller is at a negedge
  task automatic run(input logic [7:0] mask, input bit cas3, input bit ign_mid, input bit ign_end);
    int c0;
    row_valid_i = mask;
    for (int r = 0; r < ROWS; r++) row_base_i[r] = $urandom;
    cas3_i = cas3;
    c0 = cyc;
    build(c0, mask, cas3);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!refresh_en_o && !done_o, "R9 flags cleared after start", {refresh_en_o, done_o}, 0);
    wait_to(c0 + W_PWR);
    chk(cmd_mode_o == 3'd0 && !cmd_vld_o, "R2 still settling", cmd_mode_o, 0);
    if (ign_mid) begin
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait_to(c0 + W_PWR + 1);
    chk(cmd_mode_o == 3'd1, "R2 NOP after settle", cmd_mode_o, 1);
    if (ign_mid) begin
      wait_to(c0 + W_PWR + W_NOP + 3);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait_to(t_norm);
    chk(!refresh_en_o && !done_o, "R8 refresh off until normal", {refresh_en_o, done_o}, 0);
    chk(cmd_mode_o == 3'd0, "R6 normal at end", cmd_mode_o, 0);
    if (ign_end) start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(refresh_en_o == 1'b1, "R8 refresh on", refresh_en_o, 1);
    chk(done_o == 1'b1, ign_end ? "R10 late start ignored" : "R9 done", done_o, 1);
    chk(ptr == n_exp, ign_mid ? "R10 schedule intact" : "R4 strobe count", ptr, n_exp);
  endtask

  initial begin
    void'($urandom(32'h1A2B));
    repeat (3) @(negedge clk_i);
    chk(cmd_mode_o == 3'd0 && !cmd_vld_o && !refresh_en_o && !done_o, "R1 reset state",
        {cmd_mode_o, cmd_vld_o, refresh_en_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cmd_mode_o == 3'd0 && !done_o, "R1 idle after reset", {cmd_mode_o, done_o}, 0);

    run(8'hFF, 1'b1, 1'b0, 1'b0);          // all rows, CAS3
    repeat (4) @(negedge clk_i);
    chk(done_o && refresh_en_o && !cmd_vld_o, "R9 held", {done_o, refresh_en_o, cmd_vld_o}, 3'b110);
    run(8'h00, 1'b0, 1'b0, 1'b0);          // no rows
    repeat (2) @(negedge clk_i);
    run(8'h01, 1'b0, 1'b1, 1'b0);          // row 0 only, starts mid-run
    repeat (2) @(negedge clk_i);
    run(8'h80, 1'b1, 1'b0, 1'b1);          // row 7, start at last running cycle
    run(8'hA5, 1'b0, 1'b0, 1'b0);          // restart in first done cycle
    chk(done_o, "R9 done before idle", done_o, 1);
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 12; i++) begin
      run(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      repeat (1 + ($urandom % 3)) @(negedge clk_i);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule